// File: doc/BRIEF.md
# Byte-Lane Pseudo-Static RAM Access Controller

This block connects a synchronous on-chip request bus to an asynchronous pseudo-static RAM of one million 16-bit words. The request side uses a valid/ready handshake. Each request carries a read/write flag, a 20-bit word address, write data and two byte-lane enables. Read data and write completions come back as a one-cycle response pulse.

On the memory side the controller drives the chip select, write strobe, output enable, the two active-low byte-lane selects, an active-high awake line (low means deep power-down), the address bus, and a data bus split into drive value, drive enable and sampled input. Each strobe window is counted in clock cycles. The count comes from the clock period parameter and the 70 ns access time.

A sleep input puts the memory into deep power-down from idle and blocks new requests. Before requests are accepted again, one idle cycle must pass after sleep is released.

Top module: `psram_async_ctrl`

## Requirements
- R1: During and right after reset the memory is deselected (chip select, write strobe and output enable all high, data drive off, both lane selects high). The awake line is high, req_ready is high and rsp_valid is low.
- R2: A write holds chip select low for W+2 cycles. W = ceil(70 / CLK_NS) + 1, which is 19 at a 4 ns clock. The write strobe is low for exactly W cycles, starting in the second cycle of chip select.
- R3: While chip select is low, the address equals the accepted address and does not change. The driven write data equals the accepted data and does not change while the drive is on.
- R4: The data drive is on during the W write-strobe cycles and one hold cycle after them. It is never on while output enable is low.
- R5: A read holds output enable high in its first chip-select cycle (turnaround) and then low for W cycles. The data is sampled in the last low cycle. rsp_valid with the data appears W+2 cycles after acceptance.
- R6: req_be bit 0 maps to the low lane (bits 7..0, select mem_lo_sel_n) and bit 1 to the high lane (bits 15..8, select mem_hi_sel_n). A lane select is low only while chip select is low and its enable is set. Read data of a disabled lane is returned as zero.
- R7: A request with req_be = 00 toggles no memory control. It completes with rsp_valid one cycle after acceptance, with rsp_rdata zero.
- R8: While sleep_req is high, req_ready is low. Once the controller is idle, the awake line goes low one cycle after sleep_req is seen. An access that is already in progress completes first.
- R9: After sleep_req falls, the awake line is high in the next cycle, and req_ready returns one cycle after that.
- R10: req_ready is low throughout every memory access. Each accepted request produces one rsp_valid pulse.
- R11: The write strobe and output enable are never low together. No control is active while the awake line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Request for deep power-down |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables, bit 0 = low byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_awake | output | 1 | Low puts memory in deep power-down |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lo_sel_n | output | 1 | Low byte-lane select, active low |
| mem_hi_sel_n | output | 1 | High byte-lane select, active low |
| mem_addr | output | 20 | Memory address |
| mem_dq_out | output | 16 | Data value to drive |
| mem_dq_oe | output | 1 | Data drive enable |
| mem_dq_in | input | 16 | Data sampled from the memory |

## Verification
Results are timed from the clock edge that accepts a request, counted as cycle 1. A write's strobe window covers cycles 2 to W+1 and its response comes in cycle W+3. A read's output-enable window covers cycles 2 to W+1 and its response comes in cycle W+2. A zero-lane request responds in cycle 1. Each scenario task samples once per cycle on the falling edge for a fixed window after acceptance. It records the cycle index of every strobe, drive and response, and compares these indices and counts with the values derived from W. The sleep tasks use the same approach for the awake line and req_ready.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WR_SETUP,
      ST_WR_PULSE,
      ST_WR_HOLD,
      ST_RD_TURN,
      ST_RD_WAIT,
      ST_SLEEP,
      ST_WAKE
   } psram_state_e;

   // strobe window: access time rounded up to whole cycles, plus one margin cycle
   function automatic int unsigned wait_cycles(input int unsigned period_ns,
                                               input int unsigned access_ns);
      return (access_ns + period_ns - 1) / period_ns + 1;
   endfunction

endpackage

// File: rtl/psram_wait_timer.sv
module psram_wait_timer #(
   parameter int unsigned CYCLES = 19
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic done
);
   localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

   if (CYCLES < 1) begin : g_bad_cycles
      $error("psram_wait_timer: CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= CNT_W'(CYCLES - 1);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/psram_lane_decode.sv
module psram_lane_decode #(
   parameter int unsigned DATA_W = 16
) (
   input  logic [1:0]        be,
   input  logic              active,
   output logic              lo_sel_n,
   output logic              hi_sel_n,
   output logic [DATA_W-1:0] keep_mask
);
   localparam int unsigned LANE_W = DATA_W / 2;

   if (DATA_W % 2 != 0) begin : g_bad_width
      $error("psram_lane_decode: DATA_W must split into two lanes");
   end

   assign lo_sel_n = !(active && be[0]);
   assign hi_sel_n = !(active && be[1]);

   for (genvar g = 0; g < 2; g++) begin : g_lane
      assign keep_mask[g*LANE_W +: LANE_W] = {LANE_W{be[g]}};
   end
endmodule

// File: rtl/psram_async_ctrl.sv
module psram_async_ctrl
   import psram_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W    = 20,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned CLK_NS    = 4,
   parameter int unsigned ACCESS_NS = 70
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep_req,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [1:0]        req_be,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mem_cs_n,
   output logic              mem_awake,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic              mem_lo_sel_n,
   output logic              mem_hi_sel_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);
   localparam int unsigned WAIT_CYC = wait_cycles(CLK_NS, ACCESS_NS);

   if (DATA_W != 16) begin : g_bad_data
      $error("psram_async_ctrl: memory has two 8-bit lanes, DATA_W must be 16");
   end
   if (CLK_NS == 0) begin : g_bad_clk
      $error("psram_async_ctrl: CLK_NS must be nonzero");
   end

   psram_state_e      state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;
   logic [1:0]        be_q;
   logic              rsp_q;
   logic              tmr_load;
   logic              tmr_done;
   logic              mem_active;
   logic              accept;
   logic [DATA_W-1:0] keep_mask;

   assign req_ready  = (state_q == ST_IDLE) && !sleep_req;
   assign accept     = req_valid && req_ready;
   assign mem_active = state_q inside {ST_WR_SETUP, ST_WR_PULSE, ST_WR_HOLD,
                                       ST_RD_TURN, ST_RD_WAIT};
   assign tmr_load   = (state_q == ST_WR_SETUP) || (state_q == ST_RD_TURN);

   psram_wait_timer #(.CYCLES(WAIT_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tmr_load),
      .done  (tmr_done)
   );

   psram_lane_decode #(.DATA_W(DATA_W)) u_lanes (
      .be        (be_q),
      .active    (mem_active),
      .lo_sel_n  (mem_lo_sel_n),
      .hi_sel_n  (mem_hi_sel_n),
      .keep_mask (keep_mask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         be_q    <= '0;
         rsp_q   <= 1'b0;
      end else begin
         rsp_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (sleep_req) begin
                  state_q <= ST_SLEEP;
               end else if (accept) begin
                  addr_q  <= req_addr;
                  wdata_q <= req_wdata;
                  be_q    <= req_be;
                  if (req_be == 2'b00) begin
                     rsp_q   <= 1'b1;
                     rdata_q <= '0;
                  end else begin
                     state_q <= req_write ? ST_WR_SETUP : ST_RD_TURN;
                  end
               end
            end
            ST_WR_SETUP: state_q <= ST_WR_PULSE;
            ST_WR_PULSE: if (tmr_done) state_q <= ST_WR_HOLD;
            ST_WR_HOLD: begin
               state_q <= ST_IDLE;
               rsp_q   <= 1'b1;
            end
            ST_RD_TURN: state_q <= ST_RD_WAIT;
            ST_RD_WAIT: begin
               if (tmr_done) begin
                  state_q <= ST_IDLE;
                  rdata_q <= mem_dq_in & keep_mask;
                  rsp_q   <= 1'b1;
               end
            end
            ST_SLEEP: if (!sleep_req) state_q <= ST_WAKE;
            ST_WAKE:  state_q <= sleep_req ? ST_SLEEP : ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_cs_n   = !mem_active;
   assign mem_we_n   = (state_q != ST_WR_PULSE);
   assign mem_oe_n   = (state_q != ST_RD_WAIT);
   assign mem_awake  = (state_q != ST_SLEEP);
   assign mem_dq_oe  = (state_q == ST_WR_PULSE) || (state_q == ST_WR_HOLD);
   assign mem_addr   = addr_q;
   assign mem_dq_out = wdata_q;
   assign rsp_valid  = rsp_q;
   assign rsp_rdata  = rdata_q;
endmodule

// File: rtl/psram_ctrl_checker.sv
module psram_ctrl_checker #(
   parameter int unsigned ADDR_W    = 20,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned CLK_NS    = 4,
   parameter int unsigned ACCESS_NS = 70
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              mem_cs_n,
   input logic              mem_awake,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic              mem_lo_sel_n,
   input logic              mem_hi_sel_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_dq_out,
   input logic              mem_dq_oe
);
   localparam int unsigned WIN   = psram_ctrl_pkg::wait_cycles(CLK_NS, ACCESS_NS);
   localparam int unsigned CNT_W = $clog2(WIN + 2);

   logic [CNT_W-1:0] we_cnt_q;
   logic [CNT_W-1:0] oe_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_cnt_q <= '0;
         oe_cnt_q <= '0;
      end else begin
         we_cnt_q <= !mem_we_n ? we_cnt_q + 1'b1 : '0;
         oe_cnt_q <= !mem_oe_n ? oe_cnt_q + 1'b1 : '0;
      end
   end

   AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> we_cnt_q == CNT_W'(WIN)); // R2
   AST_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> $past(!mem_cs_n)); // R2
   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R3
   AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out)); // R3
   AST_DQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mem_we_n) && !mem_cs_n) |-> mem_dq_oe); // R4
   AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n); // R4
   AST_OE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |-> (oe_cnt_q == CNT_W'(WIN)) && rsp_valid); // R5
   AST_LANES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cs_n |-> (mem_lo_sel_n && mem_hi_sel_n)); // R6
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cs_n |-> !req_ready); // R10
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_we_n && !mem_oe_n)); // R11
   AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_awake |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe)); // R11
endmodule

bind psram_async_ctrl psram_ctrl_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_NS(CLK_NS), .ACCESS_NS(ACCESS_NS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_ready    (req_ready),
   .rsp_valid    (rsp_valid),
   .mem_cs_n     (mem_cs_n),
   .mem_awake    (mem_awake),
   .mem_we_n     (mem_we_n),
   .mem_oe_n     (mem_oe_n),
   .mem_lo_sel_n (mem_lo_sel_n),
   .mem_hi_sel_n (mem_hi_sel_n),
   .mem_addr     (mem_addr),
   .mem_dq_out   (mem_dq_out),
   .mem_dq_oe    (mem_dq_oe)
);

// File: tb/psram_async_ctrl_tb.sv
`timescale 1ns/1ps
module psram_async_ctrl_tb;
   localparam int W    = (70 + 4 - 1) / 4 + 1;
   localparam int NWIN = W + 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sleep_req = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [19:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic        rsp_valid;
   logic [15:0] rsp_rdata;
   logic        mem_cs_n, mem_awake, mem_we_n, mem_oe_n;
   logic        mem_lo_sel_n, mem_hi_sel_n, mem_dq_oe;
   logic [19:0] mem_addr;
   logic [15:0] mem_dq_out, mem_dq_in;

   int n_pass = 0, n_fail = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   psram_async_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_cs_n(mem_cs_n), .mem_awake(mem_awake), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .mem_lo_sel_n(mem_lo_sel_n), .mem_hi_sel_n(mem_hi_sel_n),
      .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in)
   );

   // memory model: 256 words indexed by the low address bits
   logic [15:0] mem_m [0:255];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem_m[i] <= 16'h0000;
      end else if (!mem_cs_n && mem_awake && !mem_we_n) begin
         if (!mem_lo_sel_n) mem_m[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
         if (!mem_hi_sel_n) mem_m[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
      end
   end
   assign mem_dq_in = (!mem_cs_n && mem_awake && mem_we_n && !mem_oe_n) ?
      {mem_hi_sel_n ? 8'hFF : mem_m[mem_addr[7:0]][15:8],
       mem_lo_sel_n ? 8'hFF : mem_m[mem_addr[7:0]][7:0]} : 16'hFFFF;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      if (ok) n_pass++;
      else begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // per-access observations, cycle 1 = first cycle after the accepting edge
   int n_cs, n_we, n_oe, n_dqoe, first_we, first_oe, last_dqoe, rsp_idx;
   int addr_bad, lane_bad, data_bad, ready_bad, awake_low_idx, n_rsp;
   logic [15:0] rdata_seen;

   task automatic issue(input bit wr, input logic [19:0] a, input logic [15:0] d,
                        input logic [1:0] be, input int sleep_at);
      n_cs = 0; n_we = 0; n_oe = 0; n_dqoe = 0; first_we = 0; first_oe = 0;
      last_dqoe = 0; rsp_idx = 0; addr_bad = 0; lane_bad = 0; data_bad = 0;
      ready_bad = 0; awake_low_idx = 0; n_rsp = 0; rdata_seen = 16'h0;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      @(posedge clk);
      for (int k = 1; k <= NWIN; k++) begin
         @(negedge clk);
         if (k == 1) req_valid = 1'b0;
         if (!mem_cs_n) begin
            n_cs++;
            if (mem_addr != a) addr_bad++;
            if (mem_lo_sel_n != !be[0] || mem_hi_sel_n != !be[1]) lane_bad++;
            if (req_ready) ready_bad++;
         end
         if (!mem_we_n) begin n_we++; if (first_we == 0) first_we = k; end
         if (!mem_oe_n) begin n_oe++; if (first_oe == 0) first_oe = k; end
         if (mem_dq_oe) begin
            n_dqoe++; last_dqoe = k;
            if (mem_dq_out != d) data_bad++;
         end
         if (rsp_valid) begin
            n_rsp++;
            if (rsp_idx == 0) begin rsp_idx = k; rdata_seen = rsp_rdata; end
         end
         if (!mem_awake && awake_low_idx == 0) awake_low_idx = k;
         if (k == sleep_at) sleep_req = 1'b1;
      end
   endtask

   task automatic t_reset();
      chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1", "controls idle",
          {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
      chk(mem_lo_sel_n && mem_hi_sel_n, "R1", "lanes idle",
          {mem_lo_sel_n, mem_hi_sel_n}, 2'b11);
      chk(mem_awake && req_ready && !rsp_valid, "R1", "awake/ready/rsp",
          {mem_awake, req_ready, rsp_valid}, 3'b110);
   endtask

   task automatic t_write(input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
      issue(1'b1, a, d, be, 0);
      chk(n_cs == W + 2, "R2", "cs low cycles", n_cs, W + 2);
      chk(n_we == W, "R2", "we low cycles", n_we, W);
      chk(first_we == 2, "R2", "first we cycle", first_we, 2);
      chk(addr_bad == 0, "R3", "address mismatches", addr_bad, 0);
      chk(data_bad == 0, "R3", "write data mismatches", data_bad, 0);
      chk(n_dqoe == W + 1 && last_dqoe == W + 2, "R4", "drive window end",
          last_dqoe, W + 2);
      chk(n_oe == 0, "R4", "oe low during write", n_oe, 0);
      chk(lane_bad == 0, "R6", "lane select mismatches", lane_bad, 0);
      chk(ready_bad == 0, "R10", "ready during access", ready_bad, 0);
      chk(rsp_idx == W + 3 && n_rsp == 1, "R10", "write response cycle", rsp_idx, W + 3);
   endtask

   task automatic t_read(input logic [19:0] a, input logic [1:0] be, input logic [15:0] exp);
      issue(1'b0, a, 16'h0, be, 0);
      chk(n_oe == W && first_oe == 2, "R5", "oe window start/len", (first_oe << 8) | n_oe,
          (2 << 8) | W);
      chk(n_we == 0 && n_dqoe == 0, "R4", "no drive on read", n_dqoe, 0);
      chk(rsp_idx == W + 2 && n_rsp == 1, "R5", "read response cycle", rsp_idx, W + 2);
      chk(rdata_seen == exp, "R6", "read data", rdata_seen, exp);
      chk(lane_bad == 0 && addr_bad == 0, "R6", "read lanes/addr", lane_bad + addr_bad, 0);
   endtask

   task automatic t_zero_be(input bit wr);
      issue(wr, 20'h00055, 16'hA5A5, 2'b00, 0);
      chk(n_cs == 0 && n_we == 0 && n_oe == 0 && n_dqoe == 0, "R7", "no memory activity",
          n_cs + n_we + n_oe + n_dqoe, 0);
      chk(rsp_idx == 1 && n_rsp == 1, "R7", "zero-lane response cycle", rsp_idx, 1);
      chk(rdata_seen == 16'h0, "R7", "zero-lane data", rdata_seen, 0);
   endtask

   task automatic t_sleep();
      int busy = 0;
      @(negedge clk);
      sleep_req = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_be = 2'b11;
      #0.1;
      chk(!req_ready, "R8", "ready with sleep", req_ready, 0);
      @(negedge clk);
      chk(!mem_awake, "R8", "awake after sleep", mem_awake, 0);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         if (!mem_cs_n || rsp_valid || mem_awake) busy++;
      end
      chk(busy == 0, "R8", "request blocked in sleep", busy, 0);
      req_valid = 1'b0; sleep_req = 1'b0;
      @(negedge clk);
      chk(mem_awake && !req_ready, "R9", "wake cycle", {mem_awake, req_ready}, 2'b10);
      @(negedge clk);
      chk(req_ready, "R9", "ready after idle cycle", req_ready, 1);
   endtask

   task automatic t_sleep_mid_access();
      issue(1'b0, 20'h00012, 16'h0, 2'b11, 3);
      chk(rsp_idx == W + 2 && n_oe == W, "R8", "access finishes under sleep", rsp_idx, W + 2);
      chk(awake_low_idx == W + 3, "R8", "awake falls after access", awake_low_idx, W + 3);
      @(negedge clk);
      sleep_req = 1'b0;
      repeat (2) @(negedge clk);
      chk(req_ready && mem_awake, "R9", "back to idle", {req_ready, mem_awake}, 2'b11);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write(20'h00012, 16'hBEEF, 2'b11);
      t_read(20'h00012, 2'b11, 16'hBEEF);
      t_write(20'h00012, 16'h1234, 2'b10);
      t_read(20'h00012, 2'b11, 16'h12EF);
      t_write(20'h00012, 16'h5566, 2'b01);
      t_read(20'h00012, 2'b01, 16'h0066);
      t_read(20'h00012, 2'b10, 16'h1200);
      t_write(20'hFFFFF, 16'hC3C3, 2'b11);
      t_read(20'hFFFFF, 2'b11, 16'hC3C3);
      t_zero_be(1'b1);
      t_zero_be(1'b0);
      t_read(20'h00012, 2'b11, 16'h1266);
      t_sleep();
      t_sleep_mid_access();
      t_read(20'hFFFFF, 2'b11, 16'hC3C3);
      finished = 1;
      $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
         $finish;
      end
   end
endmodule